// File: doc/BRIEF.md
# Lossy Last-Value Fast Channel Bank

This block holds a small bank of mailbox words that a sender overwrites at will and a receiver reads back at will. Each channel behaves like a RAM location that raises an interrupt when it is written: a later write simply replaces the earlier value, whether or not the receiver saw it. The sender gets no acknowledgement of any kind. The receiver sees a level-sensitive pending flag per channel. It masks that flag per channel, clears it by writing ones to a clear vector, and also sees it OR-combined into group interrupts that each cover a run of neighbouring channels.

The word width is 32 or 64 bits. The sender port is always 32 bits wide. A 64-bit word is written as two halves, and only the write of the upper half counts as a transfer and raises the interrupt. The receiver read port returns the whole word of the selected channel without delay.

Top module: `fch_bank_top`

## Requirements
- R1: After reset every channel word reads zero, no pending flag is set and every interrupt output is low.
- R2: A read of a channel returns the data of the most recent write to it. A later write overwrites an unread value, and the older value is lost.
- R3: With 64-bit words, a write with `snd_wr_hi`=0 updates bits [31:0] of the word, leaves bits [63:32] unchanged and does not set the pending flag.
- R4: A write with `snd_wr_hi`=1 updates bits [63:32] (with 32-bit words, a write updates the whole word whatever `snd_wr_hi` is). It sets the pending flag of that channel, which is visible on the cycle after the write.
- R5: A pending flag stays set until a cycle with `rcv_clr_en`=1 and a 1 in that channel's bit of `rcv_clr_bits`. Bits that are 0 in the clear vector have no effect.
- R6: When a transfer and a clear hit the same channel in one cycle, the flag stays set.
- R7: `rcv_irq_ch[c]` is high exactly when channel c is pending and `rcv_mask[c]`=1. The mask does not alter the pending flags, so unmasking later exposes a transfer that arrived while the channel was masked.
- R8: `rcv_irq_grp[g]` is the OR of `rcv_irq_ch` over channels g*GRP_SIZE up to g*GRP_SIZE+GRP_SIZE-1 (the last group may be short). With the defaults, group 0 covers channels 0..3 and group 1 covers channels 4..5.
- R9: A write whose channel index is NUM_CH or higher changes no word and sets no flag.
- R10: Reading a channel does not change its pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_wr_en | input | 1 | Sender write strobe |
| snd_wr_ch | input | CH_W | Channel to write |
| snd_wr_hi | input | 1 | Selects the upper half (64-bit words); an upper-half write is a transfer |
| snd_wr_data | input | 32 | Write data |
| rcv_rd_ch | input | CH_W | Channel to read |
| rcv_rd_data | output | WORD_W | Word of the selected channel, combinational |
| rcv_clr_en | input | 1 | Apply the clear vector this cycle |
| rcv_clr_bits | input | NUM_CH | Write-one-to-clear pending bits |
| rcv_mask | input | NUM_CH | Per-channel interrupt enable |
| rcv_irq_ch | output | NUM_CH | Masked per-channel level interrupts |
| rcv_irq_grp | output | NUM_GRP | Group level interrupts |

## Verification
The directed patterns separate the lower-half write from the upper-half write, which shows that the data lane and the interrupt trigger are independent. Repeated writes without a read show that the bank keeps the last value and does not queue. A transfer and a clear hitting the same channel show whether set or clear wins. Writes to the two channel indices beyond the bank and toggling of the mask show that neither leaks into the data or the pending state. A random phase then mixes writes, clears and mask changes across all channels and group boundaries, and compares every word and both interrupt vectors with a bench model each cycle.

// File: rtl/fch_pkg.sv
package fch_pkg;
    localparam int HALF_W = 32;

    function automatic int ch_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/fch_word_bank.sv
module fch_word_bank #(
    parameter int NUM_CH = 6,
    parameter int WORD_W = 64,
    parameter int CH_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CH_W-1:0]               wr_ch,
    input  logic                          wr_hi,
    input  logic [fch_pkg::HALF_W-1:0]    wr_data,
    input  logic [CH_W-1:0]               rd_ch,
    output logic [WORD_W-1:0]             rd_data,
    output logic [NUM_CH-1:0]             xfer_set
);
    localparam int LANES = WORD_W / fch_pkg::HALF_W;

    typedef struct packed {
        logic [NUM_CH-1:0][WORD_W-1:0] mem;
    } bank_t;

    bank_t st_d, st_q;
    logic  wr_ok;

    always_comb begin
        st_d     = st_q;
        xfer_set = '0;
        wr_ok    = wr_en && (int'(wr_ch) < NUM_CH);
        if (wr_ok) begin
            if (wr_hi || LANES == 1) begin
                st_d.mem[wr_ch][WORD_W-1 -: fch_pkg::HALF_W] = wr_data;
                xfer_set[wr_ch] = 1'b1;
            end else begin
                st_d.mem[wr_ch][fch_pkg::HALF_W-1:0] = wr_data;
            end
        end
        rd_data = (int'(rd_ch) < NUM_CH) ? st_q.mem[rd_ch] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fch_irq_ctrl.sv
module fch_irq_ctrl #(
    parameter int NUM_CH   = 6,
    parameter int GRP_SIZE = 4,
    parameter int NUM_GRP  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  set,
    input  logic               clr_en,
    input  logic [NUM_CH-1:0]  clr,
    input  logic [NUM_CH-1:0]  mask,
    output logic [NUM_CH-1:0]  pend,
    output logic [NUM_CH-1:0]  irq_ch,
    output logic [NUM_GRP-1:0] irq_grp
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
    } irq_st_t;

    irq_st_t st_d, st_q;

    // set is applied after clear: a same-cycle transfer wins
    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~(clr_en ? clr : '0)) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend   = st_q.pend;
    assign irq_ch = st_q.pend & mask;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LO = g * GRP_SIZE;
        localparam int HI = ((LO + GRP_SIZE) > NUM_CH) ? NUM_CH - 1 : LO + GRP_SIZE - 1;
        assign irq_grp[g] = |irq_ch[HI:LO];
    end
endmodule

// File: rtl/fch_bank_top.sv
module fch_bank_top #(
    parameter int NUM_CH   = 6,
    parameter int WORD_W   = 64,
    parameter int GRP_SIZE = 4,
    parameter int CH_W     = fch_pkg::ch_width(NUM_CH),
    parameter int NUM_GRP  = (NUM_CH + GRP_SIZE - 1) / GRP_SIZE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       snd_wr_en,
    input  logic [CH_W-1:0]            snd_wr_ch,
    input  logic                       snd_wr_hi,
    input  logic [fch_pkg::HALF_W-1:0] snd_wr_data,
    input  logic [CH_W-1:0]            rcv_rd_ch,
    output logic [WORD_W-1:0]          rcv_rd_data,
    input  logic                       rcv_clr_en,
    input  logic [NUM_CH-1:0]          rcv_clr_bits,
    input  logic [NUM_CH-1:0]          rcv_mask,
    output logic [NUM_CH-1:0]          rcv_irq_ch,
    output logic [NUM_GRP-1:0]         rcv_irq_grp
);
    logic [NUM_CH-1:0] xfer_set;
    logic [NUM_CH-1:0] pend;

    fch_word_bank #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .CH_W(CH_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(snd_wr_en), .wr_ch(snd_wr_ch), .wr_hi(snd_wr_hi), .wr_data(snd_wr_data),
        .rd_ch(rcv_rd_ch), .rd_data(rcv_rd_data), .xfer_set(xfer_set)
    );

    fch_irq_ctrl #(.NUM_CH(NUM_CH), .GRP_SIZE(GRP_SIZE), .NUM_GRP(NUM_GRP)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(xfer_set),
        .clr_en(rcv_clr_en), .clr(rcv_clr_bits), .mask(rcv_mask),
        .pend(pend), .irq_ch(rcv_irq_ch), .irq_grp(rcv_irq_grp)
    );
endmodule

// File: rtl/fch_bank_chk.sv
module fch_bank_chk #(
    parameter int NUM_CH  = 6,
    parameter int WORD_W  = 64,
    parameter int CH_W    = 3,
    parameter int NUM_GRP = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       snd_wr_en,
    input logic [CH_W-1:0]            snd_wr_ch,
    input logic                       snd_wr_hi,
    input logic [fch_pkg::HALF_W-1:0] snd_wr_data,
    input logic [CH_W-1:0]            rcv_rd_ch,
    input logic [WORD_W-1:0]          rcv_rd_data,
    input logic                       rcv_clr_en,
    input logic [NUM_CH-1:0]          pend,
    input logic [NUM_CH-1:0]          rcv_irq_ch,
    input logic [NUM_GRP-1:0]         rcv_irq_grp
);
    localparam int LANES = WORD_W / fch_pkg::HALF_W;

    logic xfer_ok;
    assign xfer_ok = snd_wr_en && (snd_wr_hi || LANES == 1) && (int'(snd_wr_ch) < NUM_CH);

    // R2: the upper (or only) lane of the read channel shows the last write
    assert_last_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok && snd_wr_ch == rcv_rd_ch) |=>
        (!$stable(rcv_rd_ch) || rcv_rd_data[WORD_W-1 -: fch_pkg::HALF_W] == $past(snd_wr_data)));

    // R3, R9: a flag only rises after a valid transfer write
    assert_rise_needs_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & ~$past(pend))) |-> $past(xfer_ok));

    // R4, R6: a transfer always leaves its flag set
    assert_xfer_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ok |=> pend[$past(snd_wr_ch)]);

    // R5: a flag only falls through a clear
    assert_fall_needs_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend) & ~pend)) |-> $past(rcv_clr_en));

    // R7: a channel interrupt needs a pending flag
    assert_irq_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_irq_ch & ~pend) == '0);

    // R8: group and channel interrupts agree on quiet
    assert_grp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_irq_ch == '0) == (rcv_irq_grp == '0));
endmodule

bind fch_bank_top fch_bank_chk #(
    .NUM_CH(NUM_CH), .WORD_W(WORD_W), .CH_W(CH_W), .NUM_GRP(NUM_GRP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .snd_wr_en(snd_wr_en), .snd_wr_ch(snd_wr_ch),
    .snd_wr_hi(snd_wr_hi), .snd_wr_data(snd_wr_data), .rcv_rd_ch(rcv_rd_ch),
    .rcv_rd_data(rcv_rd_data), .rcv_clr_en(rcv_clr_en), .pend(pend),
    .rcv_irq_ch(rcv_irq_ch), .rcv_irq_grp(rcv_irq_grp)
);

// File: tb/sim_fch_bank_top.sv
`timescale 1ns/100ps
module sim_fch_bank_top;
    localparam int NCH = 6;
    localparam int GS  = 4;
    localparam int NG  = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0, wr_hi = 0, clr_en = 0;
    logic [2:0] wr_ch = 0, rd_ch = 0;
    logic [31:0] wr_data = 0;
    logic [NCH-1:0] clr_bits = 0, mask = 0;
    logic [63:0] rd_data;
    logic [NCH-1:0] irq_ch;
    logic [NG-1:0] irq_grp;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [63:0]    m_mem [NCH];
    logic [NCH-1:0] m_pend;

    always #5 clk = ~clk;

    fch_bank_top u0 (
        .clk(clk), .rst_n(rst_n), .snd_wr_en(wr_en), .snd_wr_ch(wr_ch),
        .snd_wr_hi(wr_hi), .snd_wr_data(wr_data), .rcv_rd_ch(rd_ch),
        .rcv_rd_data(rd_data), .rcv_clr_en(clr_en), .rcv_clr_bits(clr_bits),
        .rcv_mask(mask), .rcv_irq_ch(irq_ch), .rcv_irq_grp(irq_grp)
    );

    function automatic logic [NG-1:0] exp_grp(input logic [NCH-1:0] v);
        logic [NG-1:0] g = '0;
        for (int c = 0; c < NCH; c++) if (v[c]) g[c / GS] = 1'b1;
        return g;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock with the given stimulus, then update the model
    task automatic cyc(input bit we, input int ch, input bit hi, input logic [31:0] d,
                       input bit ce, input logic [NCH-1:0] cb);
        logic [NCH-1:0] set = '0;
        wr_en = we; wr_ch = 3'(ch); wr_hi = hi; wr_data = d; clr_en = ce; clr_bits = cb;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; clr_en = 0;
        if (we && ch < NCH) begin
            if (hi) begin m_mem[ch][63:32] = d; set[ch] = 1'b1; end
            else    m_mem[ch][31:0] = d;
        end
        m_pend = (m_pend & ~(ce ? cb : '0)) | set;
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            rd_ch = 3'(c);
            #0.5;
            chk({tag, " word"}, rd_data, m_mem[c]);
        end
        chk({tag, " irq_ch"}, 64'(irq_ch), 64'(m_pend & mask));
        chk({tag, " irq_grp"}, 64'(irq_grp), 64'(exp_grp(m_pend & mask)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240407));
        for (int c = 0; c < NCH; c++) m_mem[c] = '0;
        m_pend = '0;
        mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");

        // R3: lower half only, no interrupt
        cyc(1, 2, 0, 32'hAAAA_0001, 0, '0);
        check_all("R3 low half");
        chk("R3 no pend", 64'(irq_ch[2]), 64'd0);
        // R4: upper half completes the transfer
        cyc(1, 2, 1, 32'h5555_0002, 0, '0);
        check_all("R4 high half");
        chk("R4 irq set", 64'(irq_ch[2]), 64'd1);
        // R2: overwrite without read, last value wins
        cyc(1, 2, 1, 32'h1111_1111, 0, '0);
        cyc(1, 2, 1, 32'h2222_2222, 0, '0);
        check_all("R2 overwrite");
        rd_ch = 3'd2; #0.5;
        chk("R2 last value", 64'(rd_data[63:32]), 64'h2222_2222);
        // R10: reading leaves flag
        @(negedge clk);
        chk("R10 read keeps pend", 64'(irq_ch[2]), 64'd1);
        // R5: clear with other bits only has no effect, then proper clear
        cyc(0, 0, 0, 0, 1, 6'b111011);
        check_all("R5 other bits");
        chk("R5 still set", 64'(irq_ch[2]), 64'd1);
        cyc(0, 0, 0, 0, 1, 6'b000100);
        check_all("R5 cleared");
        chk("R5 low", 64'(irq_ch[2]), 64'd0);
        // R6: set and clear in the same cycle
        cyc(1, 4, 1, 32'hDEAD_BEEF, 1, 6'b010000);
        check_all("R6 collision");
        chk("R6 set wins", 64'(irq_ch[4]), 64'd1);
        chk("R8 group1", 64'(irq_grp), 64'b10);
        // R7: masked pending, later unmasked
        mask = 6'b101111;
        cyc(1, 4, 1, 32'h0000_0044, 0, '0);
        check_all("R7 masked");
        chk("R7 hidden", 64'(irq_grp), 64'd0);
        mask = '1;
        #0.5;
        check_all("R7 unmasked");
        chk("R7 shown", 64'(irq_ch[4]), 64'd1);
        // R9: out-of-range channels
        cyc(1, 6, 1, 32'hBAD0_0006, 0, '0);
        cyc(1, 7, 0, 32'hBAD0_0007, 0, '0);
        check_all("R9 out of range");
        // R8: group 0 boundary
        cyc(1, 3, 1, 32'h0000_0033, 0, '0);
        check_all("R8 group0");
        chk("R8 both groups", 64'(irq_grp), 64'b11);

        // random phase
        for (int i = 0; i < 400; i++) begin
            mask = NCH'($urandom);
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7), 1'($urandom),
                $urandom, $urandom_range(0, 2) == 0, NCH'($urandom));
            check_all("R2 R7 R8 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule